// File: doc/BRIEF.md
# Overlapping Register Window File

This block is the windowed integer register file of a small RISC-style core. Its physical storage holds six register windows in a ring. Each window owns a parameter area and a local area. A third area, the outgoing-argument area, is not separate storage: it is the parameter area of the next deeper window. A caller writes arguments into its outgoing area, executes a call, and the callee finds them in its own parameter registers without any copying. Results come back the same way on return. An optional small bank of shared registers sits beside the windows and does not move with them.

The core issues logical register numbers. The block translates each one through the current window pointer into a physical register. The translation feeds two combinational read ports and one write port.

A second pointer marks the oldest window that is still resident. A call that would move the current window onto it starts an overflow: the oldest window's parameter and local areas go out word by word through a single memory port to a descending stack address. A return past the oldest resident window starts an underflow, which brings the most recently spilled window back from memory. While either transfer runs, the block reports busy and ignores register writes and new commands.

Top module: `rwin_file`

## Requirements
- R1: After reset the current window and the oldest resident window are both 0, busy is low, and every register reads as zero.
- R2: Logical registers 0–3 select the parameter area, 4–7 the local area and 8–11 the outgoing area of the current window. The outgoing area of window w is the same storage as the parameter area of window (w+1) mod 6.
- R3: A call moves the current window to (w+1) mod 6 when that window is not the oldest resident one. A return moves it to (w−1) mod 6 when w is not the oldest resident window. Each window has its own local area.
- R4: Logical registers 12–15 reach four shared registers that read the same in every window.
- R5: After reset the first five calls need no memory traffic. A call whose target equals the oldest resident window spills that window first. The spill is 8 writes: parameters 0–3, then locals 0–3. They go to descending addresses starting one below the spill stack pointer, which starts at SP_INIT. After the spill, the oldest pointer advances by one and the current window becomes the call target.
- R6: A return issued while the current window is the oldest resident one, with at least one window in memory, refills window (w−1) mod 6. The refill is 8 reads from ascending addresses starting at the spill stack pointer. It restores the spilled parameter and local values. Afterwards both pointers equal the refilled window.
- R7: While busy is high, writes, calls and returns are ignored.
- R8: A return at the oldest resident window with nothing in memory is ignored and causes no memory access.
- R9: When call and return are requested in the same cycle, only the call is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| call_i | input | 1 | Procedure call command |
| ret_i | input | 1 | Procedure return command |
| rd_a_addr | input | 4 | Logical register number, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_addr | input | 4 | Logical register number, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Logical register number to write |
| wr_data | input | 32 | Write data |
| busy | output | 1 | Spill or refill in progress |
| cur_win | output | 3 | Current window pointer |
| old_win | output | 3 | Oldest resident window pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 32 | Spill write data |
| mem_rdata | input | 32 | Refill read data, valid the cycle after a read request |

## Verification
The bench keeps the default six windows of four-register areas with the shared bank enabled. It sets SP_INIT to 64, so spilled words land in a 64-word model memory where individual addresses can be checked. Because the ring is six windows long, a chain of five calls and one more reaches the wrap-around overflow. Five returns and one more then reach the refill, so spill order, restored values and pointer motion are all observed within a few dozen cycles.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SPILL = 2'd1,
        ST_FILL  = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/rwin_map.sv
module rwin_map #(
    parameter int NWIN = 6,
    parameter int AREA = 4
) (
    input  logic [$clog2(NWIN)-1:0]        cwp,
    input  logic [$clog2(4*AREA)-1:0]      laddr,
    output logic [$clog2(NWIN*2*AREA)-1:0] phys_idx,
    output logic                           is_glob,
    output logic [$clog2(AREA)-1:0]        glob_idx
);
    localparam int TWO_A = 2 * AREA;
    localparam int PI_W  = $clog2(NWIN * TWO_A);
    localparam int G_W   = $clog2(AREA);

    int area_n;
    int offs;
    int win_n;
    int nxt_n;

    always_comb begin
        area_n   = int'(laddr) / AREA;
        offs     = int'(laddr) % AREA;
        win_n    = int'(cwp);
        nxt_n    = (win_n == NWIN - 1) ? 0 : win_n + 1;
        is_glob  = 1'b0;
        glob_idx = G_W'(offs);
        phys_idx = '0;
        case (area_n)
            0:       phys_idx = PI_W'(win_n * TWO_A + offs);
            1:       phys_idx = PI_W'(win_n * TWO_A + AREA + offs);
            2:       phys_idx = PI_W'(nxt_n * TWO_A + offs);
            default: is_glob  = 1'b1;
        endcase
    end
endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
    parameter int NWIN     = 6,
    parameter int AREA     = 4,
    parameter int WIDTH    = 32,
    parameter bit HAS_GLOB = 1'b1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [$clog2(NWIN*2*AREA)-1:0] ra_idx,
    input  logic                           ra_glob,
    input  logic [$clog2(AREA)-1:0]        ra_gidx,
    output logic [WIDTH-1:0]               ra_data,
    input  logic [$clog2(NWIN*2*AREA)-1:0] rb_idx,
    input  logic                           rb_glob,
    input  logic [$clog2(AREA)-1:0]        rb_gidx,
    output logic [WIDTH-1:0]               rb_data,
    input  logic                           wr_en,
    input  logic [$clog2(NWIN*2*AREA)-1:0] w_idx,
    input  logic                           w_glob,
    input  logic [$clog2(AREA)-1:0]        w_gidx,
    input  logic [WIDTH-1:0]               w_data,
    input  logic                           fill_en,
    input  logic [$clog2(NWIN*2*AREA)-1:0] fill_idx,
    input  logic [WIDTH-1:0]               fill_data,
    input  logic [$clog2(NWIN*2*AREA)-1:0] sp_idx,
    output logic [WIDTH-1:0]               sp_data
);
    localparam int NPHYS = NWIN * 2 * AREA;

    logic [WIDTH-1:0] regs_q [NPHYS];
    logic [WIDTH-1:0] regs_d [NPHYS];
    logic [WIDTH-1:0] glob_a;
    logic [WIDTH-1:0] glob_b;

    always_comb begin
        for (int i = 0; i < NPHYS; i++) regs_d[i] = regs_q[i];
        if (fill_en)
            regs_d[fill_idx] = fill_data;
        else if (wr_en && !w_glob)
            regs_d[w_idx] = w_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < NPHYS; i++) regs_q[i] <= regs_d[i];
        end
    end

    generate
        if (HAS_GLOB) begin : g_glob
            logic [WIDTH-1:0] gbank_q [AREA];
            logic [WIDTH-1:0] gbank_d [AREA];

            always_comb begin
                for (int i = 0; i < AREA; i++) gbank_d[i] = gbank_q[i];
                if (wr_en && w_glob && !fill_en) gbank_d[w_gidx] = w_data;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < AREA; i++) gbank_q[i] <= '0;
                end else begin
                    for (int i = 0; i < AREA; i++) gbank_q[i] <= gbank_d[i];
                end
            end

            assign glob_a = gbank_q[ra_gidx];
            assign glob_b = gbank_q[rb_gidx];
        end else begin : g_noglob
            assign glob_a = '0;
            assign glob_b = '0;
        end
    endgenerate

    assign ra_data = ra_glob ? glob_a : regs_q[ra_idx];
    assign rb_data = rb_glob ? glob_b : regs_q[rb_idx];
    assign sp_data = regs_q[sp_idx];
endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
    import rwin_pkg::*;
#(
    parameter int              NWIN    = 6,
    parameter int              AREA    = 4,
    parameter int              ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] SP_INIT = 16'h1000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           call_i,
    input  logic                           ret_i,
    output logic                           busy,
    output logic [$clog2(NWIN)-1:0]        cwp,
    output logic [$clog2(NWIN)-1:0]        swp,
    output logic                           mem_req,
    output logic                           mem_we,
    output logic [ADDR_W-1:0]              mem_addr,
    output logic [$clog2(NWIN*2*AREA)-1:0] sp_idx,
    output logic                           fill_en,
    output logic [$clog2(NWIN*2*AREA)-1:0] fill_idx
);
    localparam int TWO_A = 2 * AREA;
    localparam int WIN_W = $clog2(NWIN);
    localparam int PI_W  = $clog2(NWIN * TWO_A);
    localparam int CNT_W = $clog2(TWO_A + 1);

    typedef struct packed {
        ctl_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [WIN_W-1:0]  cwp;
        logic [WIN_W-1:0]  swp;
        logic [WIN_W-1:0]  tgt;
        logic [ADDR_W-1:0] sp;
    } ctl_t;

    ctl_t s_q, s_d;

    function automatic logic [WIN_W-1:0] win_inc(input logic [WIN_W-1:0] w);
        return (w == WIN_W'(NWIN - 1)) ? '0 : w + 1'b1;
    endfunction

    function automatic logic [WIN_W-1:0] win_dec(input logic [WIN_W-1:0] w);
        return (w == '0) ? WIN_W'(NWIN - 1) : w - 1'b1;
    endfunction

    always_comb begin
        s_d      = s_q;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = s_q.sp;
        sp_idx   = PI_W'(int'(s_q.tgt) * TWO_A + int'(s_q.cnt));
        fill_en  = 1'b0;
        fill_idx = PI_W'(int'(s_q.tgt) * TWO_A + TWO_A - int'(s_q.cnt));
        case (s_q.st)
            ST_IDLE: begin
                if (call_i) begin
                    if (win_inc(s_q.cwp) == s_q.swp) begin
                        s_d.st  = ST_SPILL;
                        s_d.cnt = '0;
                        s_d.tgt = s_q.swp;
                    end else begin
                        s_d.cwp = win_inc(s_q.cwp);
                    end
                end else if (ret_i) begin
                    if (s_q.cwp != s_q.swp) begin
                        s_d.cwp = win_dec(s_q.cwp);
                    end else if (s_q.sp != SP_INIT) begin
                        s_d.st  = ST_FILL;
                        s_d.cnt = '0;
                        s_d.tgt = win_dec(s_q.swp);
                    end
                end
            end
            ST_SPILL: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = s_q.sp - 1'b1;
                s_d.sp   = s_q.sp - 1'b1;
                s_d.cnt  = s_q.cnt + 1'b1;
                if (s_q.cnt == CNT_W'(TWO_A - 1)) begin
                    s_d.st  = ST_IDLE;
                    s_d.swp = win_inc(s_q.swp);
                    s_d.cwp = s_q.tgt;
                end
            end
            ST_FILL: begin
                if (s_q.cnt < CNT_W'(TWO_A)) begin
                    mem_req = 1'b1;
                    s_d.sp  = s_q.sp + 1'b1;
                end
                if (s_q.cnt != '0) fill_en = 1'b1;
                s_d.cnt = s_q.cnt + 1'b1;
                if (s_q.cnt == CNT_W'(TWO_A)) begin
                    s_d.st  = ST_IDLE;
                    s_d.cwp = s_q.tgt;
                    s_d.swp = s_q.tgt;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st  <= ST_IDLE;
            s_q.cnt <= '0;
            s_q.cwp <= '0;
            s_q.swp <= '0;
            s_q.tgt <= '0;
            s_q.sp  <= SP_INIT;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.st != ST_IDLE);
    assign cwp  = s_q.cwp;
    assign swp  = s_q.swp;
endmodule

// File: rtl/rwin_file.sv
module rwin_file #(
    parameter int                NWIN     = 6,
    parameter int                AREA     = 4,
    parameter int                WIDTH    = 32,
    parameter int                ADDR_W   = 16,
    parameter bit                HAS_GLOB = 1'b1,
    parameter logic [ADDR_W-1:0] SP_INIT  = 16'h1000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      call_i,
    input  logic                      ret_i,
    input  logic [$clog2(4*AREA)-1:0] rd_a_addr,
    output logic [WIDTH-1:0]          rd_a_data,
    input  logic [$clog2(4*AREA)-1:0] rd_b_addr,
    output logic [WIDTH-1:0]          rd_b_data,
    input  logic                      wr_en,
    input  logic [$clog2(4*AREA)-1:0] wr_addr,
    input  logic [WIDTH-1:0]          wr_data,
    output logic                      busy,
    output logic [$clog2(NWIN)-1:0]   cur_win,
    output logic [$clog2(NWIN)-1:0]   old_win,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [WIDTH-1:0]          mem_wdata,
    input  logic [WIDTH-1:0]          mem_rdata
);
    localparam int LA_W  = $clog2(4 * AREA);
    localparam int PI_W  = $clog2(NWIN * 2 * AREA);
    localparam int G_W   = $clog2(AREA);
    localparam int NPORT = 3;

    logic [LA_W-1:0] la   [NPORT];
    logic [PI_W-1:0] pidx [NPORT];
    logic            glb  [NPORT];
    logic [G_W-1:0]  gidx [NPORT];

    logic            call_ok, ret_ok, wr_ok;
    logic [PI_W-1:0] sp_idx, fill_idx;
    logic            fill_en;

    assign la[0] = rd_a_addr;
    assign la[1] = rd_b_addr;
    assign la[2] = wr_addr;

    assign call_ok = call_i & ~busy;
    assign ret_ok  = ret_i & ~busy & ~call_i;
    assign wr_ok   = wr_en & ~busy;

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_xlat
            rwin_map #(.NWIN(NWIN), .AREA(AREA)) u_map (
                .cwp      (cur_win),
                .laddr    (la[p]),
                .phys_idx (pidx[p]),
                .is_glob  (glb[p]),
                .glob_idx (gidx[p])
            );
        end
    endgenerate

    rwin_ctrl #(
        .NWIN(NWIN), .AREA(AREA), .ADDR_W(ADDR_W), .SP_INIT(SP_INIT)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .call_i   (call_ok),
        .ret_i    (ret_ok),
        .busy     (busy),
        .cwp      (cur_win),
        .swp      (old_win),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .sp_idx   (sp_idx),
        .fill_en  (fill_en),
        .fill_idx (fill_idx)
    );

    rwin_store #(
        .NWIN(NWIN), .AREA(AREA), .WIDTH(WIDTH), .HAS_GLOB(HAS_GLOB)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .ra_idx    (pidx[0]),
        .ra_glob   (glb[0]),
        .ra_gidx   (gidx[0]),
        .ra_data   (rd_a_data),
        .rb_idx    (pidx[1]),
        .rb_glob   (glb[1]),
        .rb_gidx   (gidx[1]),
        .rb_data   (rd_b_data),
        .wr_en     (wr_ok),
        .w_idx     (pidx[2]),
        .w_glob    (glb[2]),
        .w_gidx    (gidx[2]),
        .w_data    (wr_data),
        .fill_en   (fill_en),
        .fill_idx  (fill_idx),
        .fill_data (mem_rdata),
        .sp_idx    (sp_idx),
        .sp_data   (mem_wdata)
    );
endmodule

// File: rtl/rwin_file_chk.sv
module rwin_file_chk #(
    parameter int NWIN   = 6,
    parameter int ADDR_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    busy,
    input logic [$clog2(NWIN)-1:0] cur_win,
    input logic [$clog2(NWIN)-1:0] old_win,
    input logic                    mem_req,
    input logic                    mem_we,
    input logic [ADDR_W-1:0]       mem_addr
);
    localparam int WIN_W = $clog2(NWIN);

    // R3
    win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_win < WIN_W'(NWIN)) && (old_win < WIN_W'(NWIN)));

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(cur_win));

    // R7
    mem_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R5
    spill_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> (!busy || (mem_req && mem_we &&
                                  mem_addr == $past(mem_addr) - 1'b1)));

    // R6
    old_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(old_win) |-> $past(busy));
endmodule

bind rwin_file rwin_file_chk #(.NWIN(NWIN), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .cur_win  (cur_win),
    .old_win  (old_win),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr)
);

// File: tb/rwin_file_test.sv
`timescale 1ns/1ps
module rwin_file_test;
    localparam logic [15:0] SPI = 16'd64;
    localparam int NV = 14;
    // vector: {req[3:0], op[1:0], addr[3:0], data[31:0]}; op 0 write, 1 read, 2 call, 3 return
    localparam logic [41:0] VEC [NV] = '{
        {4'd2, 2'd0, 4'd4,  32'h0000_00A0},
        {4'd2, 2'd0, 4'd8,  32'h0000_0080},
        {4'd4, 2'd0, 4'd13, 32'h0000_0D0D},
        {4'd3, 2'd2, 4'd0,  32'd1},
        {4'd2, 2'd1, 4'd0,  32'h0000_0080},
        {4'd3, 2'd1, 4'd4,  32'h0000_0000},
        {4'd4, 2'd1, 4'd13, 32'h0000_0D0D},
        {4'd2, 2'd0, 4'd9,  32'h0000_0091},
        {4'd3, 2'd2, 4'd0,  32'd2},
        {4'd2, 2'd1, 4'd1,  32'h0000_0091},
        {4'd3, 2'd3, 4'd0,  32'd1},
        {4'd3, 2'd3, 4'd0,  32'd0},
        {4'd3, 2'd1, 4'd4,  32'h0000_00A0},
        {4'd2, 2'd1, 4'd8,  32'h0000_0080}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_i = 1'b0, ret_i = 1'b0, wr_en = 1'b0;
    logic [3:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_a_data, rd_b_data, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        busy, mem_req, mem_we;
    logic [2:0]  cur_win, old_win;
    logic [15:0] mem_addr;
    logic [15:0] last_wa = '0;
    logic [31:0] mem [64];
    int          n_wr = 0, n_rd = 0;
    int          n_tests = 0, n_fail = 0;

    rwin_file #(.SP_INIT(SPI)) uut (
        .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .cur_win(cur_win), .old_win(old_win),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                mem[mem_addr[5:0]] <= mem_wdata;
                last_wa <= mem_addr;
                n_wr <= n_wr + 1;
            end else begin
                mem_rdata <= mem[mem_addr[5:0]];
                n_rd <= n_rd + 1;
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 100) begin
            step();
            guard++;
        end
    endtask

    task automatic do_call();
        call_i = 1'b1; step(); call_i = 1'b0; wait_idle();
    endtask

    task automatic do_ret();
        ret_i = 1'b1; step(); ret_i = 1'b0; wait_idle();
    endtask

    task automatic do_wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d; step(); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        rd_b_addr = a; #0.5; v = rd_b_data;
    endtask

    function automatic string tag_of(input logic [3:0] r);
        case (r)
            4'd2:    return "R2";
            4'd3:    return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic apply_reset();
        rst_n = 1'b0; step(); step(); rst_n = 1'b1; step();
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: got %h expected %h", 32'd1, 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int wr0, rd0;
        apply_reset();

        // R1 reset state
        chk("R1 cur_win", 32'(cur_win), 32'd0);
        chk("R1 old_win", 32'(old_win), 32'd0);
        chk("R1 busy", 32'(busy), 32'd0);
        rd_a_addr = 4'd5; rd(4'd9, v);
        chk("R1 read A", rd_a_data, 32'd0);
        chk("R1 read B", v, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            op = VEC[i][37:36];
            case (op)
                2'd0: do_wr(VEC[i][35:32], VEC[i][31:0]);
                2'd1: begin
                    rd(VEC[i][35:32], v);
                    chk(tag_of(VEC[i][41:38]), v, VEC[i][31:0]);
                end
                2'd2: begin
                    do_call();
                    chk(tag_of(VEC[i][41:38]), 32'(cur_win), VEC[i][31:0]);
                end
                default: begin
                    do_ret();
                    chk(tag_of(VEC[i][41:38]), 32'(cur_win), VEC[i][31:0]);
                end
            endcase
        end

        apply_reset();
        wr0 = n_wr; rd0 = n_rd;
        // R8 return with nothing saved
        do_ret();
        chk("R8 cur_win", 32'(cur_win), 32'd0);
        chk("R8 mem ops", 32'(n_wr + n_rd - wr0 - rd0), 32'd0);

        // R9 call and return together
        call_i = 1'b1; ret_i = 1'b1; step(); call_i = 1'b0; ret_i = 1'b0;
        chk("R9 cur_win", 32'(cur_win), 32'd1);
        do_ret();

        // R5 overflow setup
        do_wr(4'd0, 32'h50);
        do_wr(4'd4, 32'd100);
        for (int w = 1; w <= 5; w++) begin
            do_call();
            chk("R3 call step", 32'(cur_win), 32'(w));
            do_wr(4'd4, 32'(100 + w));
        end
        chk("R5 no spill in five calls", 32'(n_wr - wr0), 32'd0);

        wr0 = n_wr;
        call_i = 1'b1; step(); call_i = 1'b0;
        chk("R7 busy on spill", 32'(busy), 32'd1);
        wr_en = 1'b1; wr_addr = 4'd5; wr_data = 32'hBAD; call_i = 1'b1;
        step();
        wr_en = 1'b0; call_i = 1'b0;
        wait_idle();
        chk("R5 spill count", 32'(n_wr - wr0), 32'd8);
        chk("R5 spill param0", mem[63], 32'h50);
        chk("R5 spill local0", mem[59], 32'd100);
        chk("R5 spill local3", mem[56], 32'd0);
        chk("R5 last addr", 32'(last_wa), 32'd56);
        chk("R5 cur_win", 32'(cur_win), 32'd0);
        chk("R5 old_win", 32'(old_win), 32'd1);

        do_wr(4'd4, 32'h999);
        for (int w = 5; w >= 1; w--) begin
            do_ret();
            chk("R3 ret step", 32'(cur_win), 32'(w));
            rd(4'd4, v);
            chk("R3 local", v, 32'(100 + w));
            if (w == 5) begin
                rd(4'd5, v);
                chk("R7 write ignored", v, 32'd0);
            end
        end

        rd0 = n_rd;
        do_ret();
        chk("R6 fill count", 32'(n_rd - rd0), 32'd8);
        chk("R6 cur_win", 32'(cur_win), 32'd0);
        chk("R6 old_win", 32'(old_win), 32'd0);
        rd(4'd4, v);
        chk("R6 local restored", v, 32'd100);
        rd(4'd0, v);
        chk("R6 param restored", v, 32'h50);

        wr0 = n_wr; rd0 = n_rd;
        do_ret();
        chk("R8 after fill", 32'(cur_win), 32'd0);
        chk("R8 no mem", 32'(n_wr + n_rd - wr0 - rd0), 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule